// File: doc/BRIEF.md
# Infrared Link Interrupt Aggregator

This block gathers the event pulses of an infrared serial link controller into sticky status bits and drives one interrupt line. The controller runs in one of three link modes: a low-speed mode, a medium-speed mode and a fast mode. Two banks of status logic exist. One serves the low-speed mode. The other is shared by the two high-speed modes. Each bank has a status register, a per-bit mask register and a write-one-to-clear register. In both banks, status bits 9 and 8 change their meaning with the mode. In low-speed mode they are receive timeout and framing error. In the high-speed modes they are abort detection and CRC error.

A control register holds the 2-bit mode field and three group mask bits. The mode field chooses which bank may raise the line, and each group mask bit can silence a whole group. A configuration register holds a receive-timeout interval, which only has a meaning in low-speed mode. Software reaches every register through a 16-bit port whose reads are combinational. The event sources are outside this block. Each bank has its own 5-bit event pulse input.

Top module: `ir_link_irq`

## Requirements
- R1: After reset, the control register reads 0x0111 (mode 00, all group masks set). The configuration register, both status registers and `irq_o` are 0. Both mask registers read 0x8B80.
- R2: The control register is at address 0. Bits 15:14 hold the mode (00 low-speed, 11 medium, 10 fast, 01 no mode). Bit 8 is the FIFO-receive group mask, bit 4 the high-speed bank mask and bit 0 the low-speed bank mask. Every other bit reads 0.
- R3: An event pulse sets its status bit, and the bit stays set until it is cleared. Event input bits 4..0 map to status bits 15, 11, 9, 8 and 7. The low-speed bank's status register is at address 2 and the high-speed bank's at address 5.
- R4: Writing 1 to a bit of a clear register clears that status bit. A 0 leaves the bit unchanged. The clear registers are at addresses 4 and 7 and always read 0.
- R5: When an event and a clear for the same bit arrive in the same cycle, the bit stays set.
- R6: In mode 00, `irq_o` is the OR of (status AND NOT mask) of the low-speed bank, forced to 0 while control bit 0 is 1.
- R7: In modes 11 and 10, `irq_o` is the OR of (status AND NOT mask) of the high-speed bank, forced to 0 while control bit 4 is 1.
- R8: The bank of the inactive mode never raises `irq_o`. In mode 01 neither bank does.
- R9: Control bit 8 has no effect on `irq_o`.
- R10: The configuration register is at address 1, with its timeout field in bits 9:8. In mode 00 a write of 0, 1 or 2 stores that value and a write of 3 leaves the field unchanged. In any other mode a write stores 0.
- R11: A write to a status register address has no effect.
- R12: The mask registers are at addresses 3 and 6. Only bits 15, 11, 9, 8 and 7 are stored. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| lo_evt_i | input | 5 | Event pulses for the low-speed bank |
| hs_evt_i | input | 5 | Event pulses for the high-speed bank |
| irq_o | output | 1 | Interrupt request |

## Verification
The main sweep covers every combination of the four mode codes, the eight group mask patterns, both banks, the five event bits, and each bit's mask open or closed. This separates bank selection, group gating, per-bit masking and the no-effect FIFO group bit from one another. At each point the status readback confirms the event-to-bit mapping. Directed cases cover:
- clears of selected bits, and a clear arriving in the same cycle as an event;
- writes to read-only and unimplemented bits;
- the timeout field with legal values, with the illegal value 3, and with writes made outside low-speed mode.

// File: rtl/ir_irq_pkg.sv
package ir_irq_pkg;
  localparam int REG_W = 16;
  localparam int EVT_N = 5;
  localparam logic [REG_W-1:0] IMPL_BITS = 16'h8B80;

  localparam logic [1:0] MODE_LOW  = 2'b00;
  localparam logic [1:0] MODE_NONE = 2'b01;
  localparam logic [1:0] MODE_FAST = 2'b10;
  localparam logic [1:0] MODE_MED  = 2'b11;

  localparam int A_CTRL   = 0;
  localparam int A_CFG    = 1;
  localparam int A_LO_SRC = 2;
  localparam int A_LO_MSK = 3;
  localparam int A_LO_CLR = 4;
  localparam int A_HS_SRC = 5;
  localparam int A_HS_MSK = 6;
  localparam int A_HS_CLR = 7;

  function automatic int evt_pos(input int k);
    case (k)
      0: evt_pos = 7;   // transmit done
      1: evt_pos = 8;   // framing / crc error
      2: evt_pos = 9;   // timeout / abort
      3: evt_pos = 11;  // area overflow
      default: evt_pos = 15;  // receive done
    endcase
  endfunction
endpackage

// File: rtl/ir_src_bank.sv
module ir_src_bank
  import ir_irq_pkg::*;
#(
  parameter int W = REG_W,
  parameter int N = EVT_N,
  parameter logic [W-1:0] IMPL = IMPL_BITS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         mask_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] src_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  logic [W-1:0] evt_bits, clr_bits, src_q, mask_q;

  always_comb begin
    evt_bits = '0;
    for (int k = 0; k < N; k++) evt_bits[evt_pos(k)] = evt_i[k];
  end

  assign clr_bits = clr_we_i ? (wdata_i & IMPL) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      mask_q <= IMPL;
    end else begin
      src_q <= (src_q & ~clr_bits) | evt_bits;  // event wins over clear
      if (mask_we_i) mask_q <= wdata_i & IMPL;
    end
  end

  assign src_o  = src_q;
  assign mask_o = mask_q;
  assign pend_o = |(src_q & ~mask_q);

  AST_EVT_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((src_q & $past(evt_bits)) == $past(evt_bits))); // R5
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((src_q & $past(wdata_i & IMPL & ~evt_bits)) == '0)); // R4
  AST_SRC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((src_q & $past(src_q)) == $past(src_q))); // R3
  AST_SRC_IMPL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q & ~IMPL) == '0); // R3
endmodule

// File: rtl/ir_ctrl_regs.sv
module ir_ctrl_regs
  import ir_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctrl_we_i,
  input  logic         cfg_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [1:0]   mode_o,
  output logic [2:0]   gmask_o,  // {fifo, hs, lo}
  output logic [1:0]   tmo_o,
  output logic [W-1:0] ctrl_rd_o,
  output logic [W-1:0] cfg_rd_o
);
  logic [1:0] mode_q, tmo_q;
  logic [2:0] gm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_LOW;
      gm_q   <= 3'b111;
      tmo_q  <= 2'b00;
    end else begin
      if (ctrl_we_i) begin
        mode_q <= wdata_i[15:14];
        gm_q   <= {wdata_i[8], wdata_i[4], wdata_i[0]};
      end
      if (cfg_we_i) begin
        if (mode_q != MODE_LOW) tmo_q <= 2'b00;
        else if (wdata_i[9:8] != 2'b11) tmo_q <= wdata_i[9:8];
      end
    end
  end

  assign mode_o  = mode_q;
  assign gmask_o = gm_q;
  assign tmo_o   = tmo_q;

  always_comb begin
    ctrl_rd_o        = '0;
    ctrl_rd_o[15:14] = mode_q;
    ctrl_rd_o[8]     = gm_q[2];
    ctrl_rd_o[4]     = gm_q[1];
    ctrl_rd_o[0]     = gm_q[0];
    cfg_rd_o         = '0;
    cfg_rd_o[9:8]    = tmo_q;
  end

  AST_TMO_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q != 2'b11); // R10
  AST_TMO_ZERO_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && mode_q != MODE_LOW) |=> (tmo_q == 2'b00)); // R10
  AST_TMO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(tmo_q)); // R10
endmodule

// File: rtl/ir_link_irq.sv
module ir_link_irq
  import ir_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int W      = REG_W,
  parameter int N      = EVT_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [N-1:0]      lo_evt_i,
  input  logic [N-1:0]      hs_evt_i,
  output logic              irq_o
);
  localparam int NBANK = 2;

  logic [1:0]   mode;
  logic [2:0]   gmask;
  logic [1:0]   tmo;
  logic [W-1:0] ctrl_rd, cfg_rd;
  logic [W-1:0] src   [NBANK];
  logic [W-1:0] msk   [NBANK];
  logic         pend  [NBANK];
  logic [N-1:0] evt   [NBANK];
  logic         lo_act, hs_act;

  assign evt[0] = lo_evt_i;
  assign evt[1] = hs_evt_i;

  ir_ctrl_regs #(.W(W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_we_i(we_i && addr_i == ADDR_W'(A_CTRL)),
    .cfg_we_i (we_i && addr_i == ADDR_W'(A_CFG)),
    .wdata_i  (wdata_i),
    .mode_o   (mode),
    .gmask_o  (gmask),
    .tmo_o    (tmo),
    .ctrl_rd_o(ctrl_rd),
    .cfg_rd_o (cfg_rd)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int MSK_A = (b == 0) ? A_LO_MSK : A_HS_MSK;
    localparam int CLR_A = (b == 0) ? A_LO_CLR : A_HS_CLR;
    ir_src_bank #(.W(W), .N(N)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt[b]),
      .mask_we_i(we_i && addr_i == ADDR_W'(MSK_A)),
      .clr_we_i (we_i && addr_i == ADDR_W'(CLR_A)),
      .wdata_i  (wdata_i),
      .src_o    (src[b]),
      .mask_o   (msk[b]),
      .pend_o   (pend[b])
    );
  end

  assign lo_act = (mode == MODE_LOW);
  assign hs_act = (mode == MODE_MED) || (mode == MODE_FAST);
  assign irq_o  = (lo_act && !gmask[0] && pend[0]) ||
                  (hs_act && !gmask[1] && pend[1]);

  always_comb begin
    case (int'(addr_i))
      A_CTRL:   rdata_o = ctrl_rd;
      A_CFG:    rdata_o = cfg_rd;
      A_LO_SRC: rdata_o = src[0];
      A_LO_MSK: rdata_o = msk[0];
      A_HS_SRC: rdata_o = src[1];
      A_HS_MSK: rdata_o = msk[1];
      default:  rdata_o = '0;
    endcase
  end

  AST_NONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_NONE) |-> !irq_o); // R8
  AST_LO_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_act && gmask[0]) |-> !irq_o); // R6
  AST_HS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_act && gmask[1]) |-> !irq_o); // R7
  AST_IRQ_HAS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((src[0] | src[1]) != '0)); // R8
endmodule

// File: tb/ir_link_irq_tb.sv
module ir_link_irq_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  addr = 0;
  logic        we = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [4:0]  lo_evt = 0, hs_evt = 0;
  logic        irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ir_link_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .lo_evt_i(lo_evt), .hs_evt_i(hs_evt), .irq_o(irq)
  );

  function automatic int posn(input int k);
    int t[5] = '{7, 8, 9, 11, 15};
    return t[k];
  endfunction

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); addr = 3'(a); wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk); addr = 3'(a); #1; d = rdata;
  endtask

  task automatic pulse(input int b, input logic [4:0] v);
    @(negedge clk);
    if (b == 0) lo_evt = v; else hs_evt = v;
    @(negedge clk); lo_evt = 0; hs_evt = 0;
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(0, d); chk("R1 ctrl", d, 16'h0111);
    rd(1, d); chk("R1 cfg", d, 16'h0000);
    rd(2, d); chk("R1 lo src", d, 16'h0000);
    rd(5, d); chk("R1 hs src", d, 16'h0000);
    rd(3, d); chk("R1 lo mask", d, 16'h8B80);
    rd(6, d); chk("R1 hs mask", d, 16'h8B80);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // R2 control register fields
    wr(0, 16'hFFFF); rd(0, d); chk("R2 ctrl all ones", d, 16'hC111);
    wr(0, 16'h3EEE); rd(0, d); chk("R2 ctrl no fields", d, 16'h0000);
    // R12 mask implemented bits
    wr(3, 16'hFFFF); rd(3, d); chk("R12 lo mask", d, 16'h8B80);
    wr(6, 16'h747F); rd(6, d); chk("R12 hs mask", d, 16'h0000);
    // R4 clear register reads 0
    rd(4, d); chk("R4 lo clr read", d, 16'h0);
    rd(7, d); chk("R4 hs clr read", d, 16'h0);

    // Main sweep: R3 R6 R7 R8 R9
    for (int m = 0; m < 4; m++)
      for (int g = 0; g < 8; g++)
        for (int b = 0; b < 2; b++)
          for (int k = 0; k < 5; k++)
            for (int mo = 0; mo < 2; mo++) begin
              logic [15:0] bitv, mval, ctrlv;
              bit act, gm, e;
              bitv = 16'(1) << posn(k);
              mval = mo ? 16'h8B80 : (16'h8B80 & ~bitv);
              ctrlv = (16'(m) << 14) | (g[2] ? 16'h0100 : 0) |
                      (g[1] ? 16'h0010 : 0) | (g[0] ? 16'h0001 : 0);
              wr(0, ctrlv);
              wr(b == 0 ? 3 : 6, mval);
              wr(b == 0 ? 6 : 3, 16'h8B80);
              pulse(b, 5'(1) << k);
              rd(b == 0 ? 2 : 5, d);
              chk("R3 src mapping", d, bitv);
              act = (b == 0) ? (m == 0) : (m == 3 || m == 2);
              gm  = (b == 0) ? g[0] : g[1];
              e   = act && !gm && !mo;
              chk($sformatf("R6/R7/R8/R9 irq m=%0d g=%0d b=%0d k=%0d mo=%0d", m, g, b, k, mo),
                  {15'b0, irq}, {15'b0, e});
              wr(b == 0 ? 4 : 7, 16'hFFFF);
              rd(b == 0 ? 2 : 5, d);
              chk("R4 clear all", d, 16'h0);
            end

    // R3 stickiness over time, R4 selective clear, R5 same-cycle
    pulse(0, 5'b11111);
    repeat (5) @(negedge clk);
    rd(2, d); chk("R3 sticky", d, 16'h8B80);
    wr(4, 16'h0880); rd(2, d); chk("R4 partial clear", d, 16'h8300);
    @(negedge clk); addr = 3'd4; wdata = 16'h8000; we = 1; lo_evt = 5'b10000;
    @(negedge clk); we = 0; lo_evt = 0;
    rd(2, d); chk("R5 event beats clear", d, 16'h8300);
    // R11 status write ignored
    wr(2, 16'h0000); rd(2, d); chk("R11 lo src write", d, 16'h8300);
    wr(5, 16'hFFFF); rd(5, d); chk("R11 hs src write", d, 16'h0000);
    wr(4, 16'hFFFF);

    // R10 timeout field
    wr(0, 16'h0111);
    wr(1, 16'h0100); rd(1, d); chk("R10 tmo 1", d, 16'h0100);
    wr(1, 16'hFEFF); rd(1, d); chk("R10 tmo 2", d, 16'h0200);
    wr(1, 16'h0300); rd(1, d); chk("R10 tmo 3 ignored", d, 16'h0200);
    wr(1, 16'h0000); rd(1, d); chk("R10 tmo 0", d, 16'h0000);
    wr(1, 16'h0200);
    wr(0, 16'hC111);
    rd(1, d); chk("R10 mode switch keeps", d, 16'h0200);
    wr(1, 16'h0100); rd(1, d); chk("R10 hs forces 0", d, 16'h0000);
    wr(0, 16'h4111);
    wr(1, 16'h0200); rd(1, d); chk("R10 none forces 0", d, 16'h0000);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule